// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an 8-bit arithmetic and logic unit that keeps its left operand in an internal accumulator. A caller presents a 3-bit opcode and an 8-bit operand together with a start strobe. On that clock edge the unit combines the accumulator with the operand and writes the result back to the accumulator. In the same edge it updates five status flags: sign, zero, auxiliary carry (out of the low nibble), even parity and carry.

Eight operations are available. Four are arithmetic: add, add with carry, subtract and subtract with borrow. Three are bitwise: AND, OR and XOR. The last is compare, which sets the flags exactly as a subtraction would but leaves the accumulator as it was. A carry-chained operation takes the stored carry flag as its carry or borrow input, so multi-byte arithmetic can be built from a sequence of commands. A one-cycle done pulse follows every executed command.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator, all five flags and done to 0.
- R2: Opcode 0 (add) writes acc+operand and opcode 1 (add with carry) writes acc+operand+carry flag, both modulo 256. The carry flag becomes the carry out of bit 7.
- R3: Opcode 2 (subtract) writes acc-operand and opcode 3 (subtract with borrow) writes acc-operand-carry flag, both modulo 256. The carry flag becomes 1 exactly when operand (plus the borrow in) exceeds acc as unsigned numbers.
- R4: Opcodes 4, 5 and 6 write acc AND, OR and XOR operand. Each clears the carry flag. The auxiliary carry becomes 1 for AND and 0 for OR and XOR.
- R5: After every executed command the sign flag equals bit 7 of the result.
- R6: After every executed command the zero flag is 1 exactly when the 8-bit result is 0.
- R7: After every executed command the parity flag is 1 exactly when the result has an even number of 1 bits.
- R8: For add operations the auxiliary carry is the carry from bit 3 into bit 4. For subtract and compare it is 1 exactly when the low nibble of the operand plus the borrow in exceeds the low nibble of acc.
- R9: Opcode 7 (compare) sets all five flags as subtract would and leaves the accumulator unchanged.
- R10: While start is low, the accumulator and flags hold regardless of opcode and operand.
- R11: done is 1 in the cycle after each rising edge at which start was high, and 0 after edges at which start was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Execute the presented command at this edge |
| opcode | input | 3 | Operation select (0..7, see R2 to R9) |
| operand | input | DATA_W | Right-hand operand |
| acc | output | DATA_W | Accumulator contents |
| flagSign | output | 1 | Sign flag |
| flagZero | output | 1 | Zero flag |
| flagAux | output | 1 | Nibble auxiliary carry flag |
| flagParity | output | 1 | Even parity flag |
| flagCarry | output | 1 | Carry / borrow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block at its default width of 8. At that width every opcode can be swept against a 32 by 32 grid of accumulator and operand values that includes 0, 255 and both nibble boundaries. Each point is run with the incoming carry flag both cleared and set. The accumulator is preloaded through the unit's own commands, so the carry and borrow chaining, the nibble borrow and the compare's untouched accumulator are all exercised against arithmetic computed in the bench. Separate idle and mid-run reset sequences cover the hold and reset behaviour.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } opCode_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicOp_e;

  typedef struct packed {
    logic     accWe;
    logic     flagWe;
    logic     subtract;
    logic     chainCarry;
    logic     isLogic;
    logicOp_e logicSel;
  } ctrl_t;

  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] opcode,
  output ctrl_t      strb,
  output logic       done
);

  opCode_e opSel;
  assign opSel = opCode_e'(opcode);

  always_comb begin
    strb = '0;
    strb.logicSel = LG_AND;
    if (start) begin
      strb.flagWe = 1'b1;
      strb.accWe  = 1'b1;
      case (opSel)
        OP_ADD: ;
        OP_ADC: strb.chainCarry = 1'b1;
        OP_SUB: strb.subtract = 1'b1;
        OP_SBB: begin
          strb.subtract   = 1'b1;
          strb.chainCarry = 1'b1;
        end
        OP_AND: begin
          strb.isLogic  = 1'b1;
          strb.logicSel = LG_AND;
        end
        OP_OR: begin
          strb.isLogic  = 1'b1;
          strb.logicSel = LG_OR;
        end
        OP_XOR: begin
          strb.isLogic  = 1'b1;
          strb.logicSel = LG_XOR;
        end
        OP_CMP: begin
          strb.subtract = 1'b1;
          strb.accWe    = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= start;
  end

  // R11: a completion pulse follows each executed command
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  // R11: no pulse after an idle edge
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             strb,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accQ,
  output flags_t            flagsQ
);

  localparam int NIB_W   = 4;
  localparam int NIB_CNT = DATA_W / NIB_W;

  logic [DATA_W-1:0]  opEff;
  logic [DATA_W-1:0]  sumVal;
  logic [DATA_W-1:0]  logicVal;
  logic [DATA_W-1:0]  resVal;
  logic [NIB_CNT:0]   nibCarry;
  logic               chainBit;
  flags_t             flagsNext;

  assign chainBit    = strb.chainCarry & flagsQ.carry;
  assign nibCarry[0] = strb.subtract ? ~chainBit : chainBit;
  assign opEff       = strb.subtract ? ~operand : operand;

  generate
    for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
      logic [NIB_W:0] nibSum;
      assign nibSum = {1'b0, accQ[g*NIB_W +: NIB_W]}
                    + {1'b0, opEff[g*NIB_W +: NIB_W]}
                    + {{NIB_W{1'b0}}, nibCarry[g]};
      assign sumVal[g*NIB_W +: NIB_W] = nibSum[NIB_W-1:0];
      assign nibCarry[g+1] = nibSum[NIB_W];
    end
  endgenerate

  always_comb begin
    case (strb.logicSel)
      LG_AND:  logicVal = accQ & operand;
      LG_OR:   logicVal = accQ | operand;
      LG_XOR:  logicVal = accQ ^ operand;
      default: logicVal = accQ & operand;
    endcase
  end

  assign resVal = strb.isLogic ? logicVal : sumVal;

  always_comb begin
    flagsNext.sign   = resVal[DATA_W-1];
    flagsNext.zero   = ~|resVal;
    flagsNext.parity = ~^resVal;
    if (strb.isLogic) begin
      flagsNext.carry = 1'b0;
      flagsNext.aux   = (strb.logicSel == LG_AND);
    end else begin
      flagsNext.carry = nibCarry[NIB_CNT] ^ strb.subtract;
      flagsNext.aux   = nibCarry[1] ^ strb.subtract;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ   <= '0;
      flagsQ <= '0;
    end else begin
      if (strb.accWe)  accQ   <= resVal;
      if (strb.flagWe) flagsQ <= flagsNext;
    end
  end

  // R5: sign tracks the written accumulator's top bit
  p_sign_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWe && strb.accWe) |=> (flagsQ.sign == accQ[DATA_W-1]));
  // R6: zero flag agrees with the written accumulator
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWe && strb.accWe) |=> (flagsQ.zero == (accQ == '0)));
  // R7: parity flag agrees with the written accumulator
  p_parity_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.flagWe && strb.accWe) |=> (flagsQ.parity == ~^accQ));
  // R4: bitwise operations leave carry cleared
  p_logic_carry_r4: assert property (@(posedge clk) disable iff (rst)
    strb.isLogic |=> !flagsQ.carry);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic              flagSign,
  output logic              flagZero,
  output logic              flagAux,
  output logic              flagParity,
  output logic              flagCarry,
  output logic              done
);

  ctrl_t  strb;
  flags_t flagsQ;

  alu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opcode (opcode),
    .strb   (strb),
    .done   (done)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .operand (operand),
    .accQ    (acc),
    .flagsQ  (flagsQ)
  );

  assign flagSign   = flagsQ.sign;
  assign flagZero   = flagsQ.zero;
  assign flagAux    = flagsQ.aux;
  assign flagParity = flagsQ.parity;
  assign flagCarry  = flagsQ.carry;

  // R9: compare never alters the accumulator
  p_cmp_keeps_acc_r9: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 3'd7) |=> $stable(acc));
  // R10: nothing moves on an idle edge
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(acc) && $stable(flagsQ)));

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [2:0] opcode;
  logic [7:0] operand;
  logic [7:0] acc;
  logic       flagSign, flagZero, flagAux, flagParity, flagCarry, done;

  int checkCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .operand(operand),
    .acc(acc), .flagSign(flagSign), .flagZero(flagZero), .flagAux(flagAux),
    .flagParity(flagParity), .flagCarry(flagCarry), .done(done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic doOp(input int op, input int b);
    opcode  = op[2:0];
    operand = b[7:0];
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failCnt++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int expAcc, res, expC, expAc, ones, cinv, holdAcc, holdC;
    string tagRes;
    rst = 1'b1; start = 1'b0; opcode = 3'd0; operand = 8'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc", acc, 0);
    chk("R1", "flags", {flagSign, flagZero, flagAux, flagParity, flagCarry}, 0);
    chk("R1", "done", done, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int op = 0; op < 8; op++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int i = 0; i < 32; i++) begin
          for (int j = 0; j < 32; j++) begin
            int a, b;
            a = i*8 + (i%8);
            b = j*8 + (j%8);
            doOp(4, 0);
            if (cin == 1 && a == 255) doOp(2, 1);
            else begin
              doOp(0, a);
              if (cin == 1) doOp(7, 255);
            end
            doOp(op, b);
            cinv = (op == 1 || op == 3) ? cin : 0;
            case (op)
              0, 1: begin
                res = (a + b + cinv) & 255;
                expC = ((a + b + cinv) > 255) ? 1 : 0;
                expAc = (((a & 15) + (b & 15) + cinv) > 15) ? 1 : 0;
                tagRes = "R2";
              end
              2, 3, 7: begin
                res = (a - b - cinv) & 255;
                expC = ((b + cinv) > a) ? 1 : 0;
                expAc = (((b & 15) + cinv) > (a & 15)) ? 1 : 0;
                tagRes = (op == 7) ? "R9" : "R3";
              end
              4: begin res = a & b; expC = 0; expAc = 1; tagRes = "R4"; end
              5: begin res = a | b; expC = 0; expAc = 0; tagRes = "R4"; end
              default: begin res = a ^ b; expC = 0; expAc = 0; tagRes = "R4"; end
            endcase
            expAcc = (op == 7) ? a : res;
            ones = 0;
            for (int k = 0; k < 8; k++) ones += (res >> k) & 1;
            chk(tagRes, "acc", acc, expAcc);
            chk(tagRes, "carry", flagCarry, expC);
            chk((op >= 4 && op <= 6) ? "R4" : "R8", "aux", flagAux, expAc);
            chk("R5", "sign", flagSign, (res >> 7) & 1);
            chk("R6", "zero", flagZero, (res == 0) ? 1 : 0);
            chk("R7", "parity", flagParity, (ones % 2 == 0) ? 1 : 0);
            chk("R11", "done", done, 1);
          end
        end
      end
    end

    // R10: idle cycles with live-looking inputs change nothing
    doOp(0, 8'h9C);
    holdAcc = acc;
    holdC   = {flagSign, flagZero, flagAux, flagParity, flagCarry};
    opcode = 3'd0; operand = 8'h77; start = 1'b0;
    @(negedge clk);
    // R11: done drops after an idle edge
    chk("R11", "done idle", done, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R10", "acc hold", acc, holdAcc);
    chk("R10", "flags hold", {flagSign, flagZero, flagAux, flagParity, flagCarry}, holdC);

    // R1: reset mid-run after a nonzero result with flags set
    doOp(2, 8'h10);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "acc", acc, 0);
    chk("R1", "flags", {flagSign, flagZero, flagAux, flagParity, flagCarry}, 0);
    chk("R1", "done", done, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", checkCnt, failCnt);
    $finish;
  end

endmodule